// File: doc/BRIEF.md
# Atomic Compare-Exchange / Exchange-Add Unit

This unit carries out two read-modify-write integer operations on an 8-bit or 16-bit operand. The first is compare-and-exchange against an accumulator. The second is exchange-and-add. A decoded request arrives in a single cycle. It carries:

- the operation;
- the operand width;
- the addressing byte, which decides between a register operand and a memory operand;
- the accumulator, source and destination-register values.

For a register destination, the unit computes the result and reports it as register write strobes. For a memory destination, it first fetches the operand through a read handshake. It then writes the result back through a write handshake when one is needed, and holds a lock output for the whole access.

Every operation finishes with a one-cycle completion pulse. The register, accumulator and flag write strobes come in that same cycle, together with a cycle-cost figure. The cost depends on the operation, on the operand kind and, for compare-exchange, on the outcome of the comparison. Address calculation, the register file and the memory system sit outside the unit.

Top module: `rmw_xchg_unit`

## Requirements
- R1: An addressing byte of 0xC0 or higher selects a register destination, which produces no memory read or write. Any value below 0xC0 selects a memory destination.
- R2: Compare-exchange with the accumulator equal to the destination writes the source value to the destination and updates the zero flag to 1. The accumulator is not written.
- R3: Compare-exchange with the accumulator different from the destination writes the destination value to the accumulator and updates the zero flag to 0. The destination is not written, neither by register strobe nor by memory write.
- R4: Exchange-add writes destination plus source to the destination and writes the old destination value to the source register. The sum wraps modulo the operand width, and the zero flag is not updated.
- R5: With `req_wide` = 0 (8-bit), only bits 7:0 take part in the compare and the add. Every written value has bits 15:8 at zero. With `req_wide` = 1, all 16 bits are used.
- R6: A memory operation issues exactly one read and holds `mem_rd_req` until `mem_rd_ack`. It then issues at most one write, held until `mem_wr_ack`. `mem_lock` is high from the first read cycle through the write-acknowledge cycle, or through the compute cycle when no write follows. It is low otherwise.
- R7: `done` is high for exactly one cycle per operation. Every register write strobe (`dst_wr_en`, `acc_wr_en`, `src_wr_en`, `zf_wr_en`) is asserted only in that cycle.
- R8: `cost` is valid only while `done` is high, and is zero otherwise. It takes one of six parameter values:
  - compare-exchange, register form: one value for match, one for mismatch;
  - compare-exchange, memory form: one value for match, one for mismatch;
  - exchange-add: one value for the register form, one for the memory form.
- R9: After reset, `req_ready` is 1 and `done`, `mem_lock`, both memory requests and all strobes are 0. `req_ready` is 1 only while no operation is in progress. Operation encoding: `req_op` = 0 selects compare-exchange, 1 selects exchange-add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted |
| req_op | input | 1 | 0 compare-exchange, 1 exchange-add |
| req_wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit |
| req_modrm | input | 8 | Addressing byte |
| req_acc | input | 16 | Accumulator value |
| req_src | input | 16 | Source register value |
| req_dst | input | 16 | Destination register value (register form) |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_ack | input | 1 | Read response valid |
| mem_rd_data | input | 16 | Read response data |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_ack | input | 1 | Write accepted |
| mem_wr_data | output | 16 | Write data |
| mem_wide | output | 1 | Access width of current operation |
| mem_lock | output | 1 | Bus lock for the access |
| dst_wr_en | output | 1 | Destination register write strobe |
| dst_wr_data | output | 16 | Destination register data |
| acc_wr_en | output | 1 | Accumulator write strobe |
| acc_wr_data | output | 16 | Accumulator data |
| src_wr_en | output | 1 | Source register write strobe |
| src_wr_data | output | 16 | Source register data |
| zf_wr_en | output | 1 | Zero flag update strobe |
| zf_value | output | 1 | New zero flag |
| done | output | 1 | Operation complete pulse |
| cost | output | COST_W | Cycle cost of the completed operation |

## Verification
The bench builds the unit with `COST_W` = 6 and overrides the six cost parameters with the distinct values 21 to 26. Any wrong choice among the six costs therefore shows up as a wrong number at the port. The data width comes from the package and stays at 16. This means the 8-bit masking of the upper byte can be exercised, along with wrap-around at both 0xFF and 0xFFFF. The memory responder can be given a read latency of zero or several cycles. This reaches both the immediate-acknowledge path and the held-request path, and it covers the addressing-byte boundary values 0xBF and 0xC0.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [7:0] REG_FORM_MIN = 8'hC0;

    typedef enum logic {
        OP_CAS  = 1'b0,
        OP_XADD = 1'b1
    } rmw_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_CALC,
        S_WR,
        S_FIN
    } rmw_state_e;

    typedef struct packed {
        rmw_op_e            op;
        logic               wide;
        logic               is_mem;
        logic [DATA_W-1:0]  acc;
        logic [DATA_W-1:0]  src;
        logic [DATA_W-1:0]  dst;
    } rmw_req_t;

    typedef struct packed {
        logic               dst_we;
        logic               acc_we;
        logic               src_we;
        logic               zf_we;
        logic               zf;
        logic               hit;
        logic [DATA_W-1:0]  dst_val;
        logic [DATA_W-1:0]  reg_val;
    } rmw_res_t;

    function automatic logic [DATA_W-1:0] width_mask(input logic wide);
        return wide ? {DATA_W{1'b1}} : DATA_W'({BYTE_W{1'b1}});
    endfunction

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
(
    input  rmw_req_t req,
    output rmw_res_t res
);
    logic [DATA_W-1:0] mask, a, s, d, sum;

    always_comb begin
        mask = width_mask(req.wide);
        a    = req.acc & mask;
        s    = req.src & mask;
        d    = req.dst & mask;
        sum  = (d + s) & mask;
        res  = '0;
        if (req.op == OP_CAS) begin
            res.zf_we = 1'b1;
            res.hit   = (a == d);
            if (a == d) begin
                res.dst_we  = 1'b1;
                res.dst_val = s;
                res.zf      = 1'b1;
            end else begin
                res.acc_we  = 1'b1;
                res.reg_val = d;
                res.zf      = 1'b0;
            end
        end else begin
            res.dst_we  = 1'b1;
            res.dst_val = sum;
            res.src_we  = 1'b1;
            res.reg_val = d;
        end
    end
endmodule

// File: rtl/rmw_cost.sv
module rmw_cost
    import rmw_pkg::*;
#(
    parameter int COST_W       = 8,
    parameter int CAS_REG_HIT  = 6,
    parameter int CAS_REG_MISS = 7,
    parameter int CAS_MEM_HIT  = 8,
    parameter int CAS_MEM_MISS = 10,
    parameter int XADD_REG     = 3,
    parameter int XADD_MEM     = 4
) (
    input  rmw_op_e           op,
    input  logic              is_mem,
    input  logic              hit,
    output logic [COST_W-1:0] cost
);
    always_comb begin
        if (op == OP_XADD)
            cost = is_mem ? COST_W'(XADD_MEM) : COST_W'(XADD_REG);
        else if (is_mem)
            cost = hit ? COST_W'(CAS_MEM_HIT) : COST_W'(CAS_MEM_MISS);
        else
            cost = hit ? COST_W'(CAS_REG_HIT) : COST_W'(CAS_REG_MISS);
    end
endmodule

// File: rtl/rmw_xchg_unit.sv
module rmw_xchg_unit
    import rmw_pkg::*;
#(
    parameter int COST_W       = 8,
    parameter int CAS_REG_HIT  = 6,
    parameter int CAS_REG_MISS = 7,
    parameter int CAS_MEM_HIT  = 8,
    parameter int CAS_MEM_MISS = 10,
    parameter int XADD_REG     = 3,
    parameter int XADD_MEM     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              req_wide,
    input  logic [7:0]        req_modrm,
    input  logic [DATA_W-1:0] req_acc,
    input  logic [DATA_W-1:0] req_src,
    input  logic [DATA_W-1:0] req_dst,
    output logic              mem_rd_req,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    input  logic              mem_wr_ack,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_wide,
    output logic              mem_lock,
    output logic              dst_wr_en,
    output logic [DATA_W-1:0] dst_wr_data,
    output logic              acc_wr_en,
    output logic [DATA_W-1:0] acc_wr_data,
    output logic              src_wr_en,
    output logic [DATA_W-1:0] src_wr_data,
    output logic              zf_wr_en,
    output logic              zf_value,
    output logic              done,
    output logic [COST_W-1:0] cost
);
    rmw_state_e        state_q;
    rmw_req_t          req_q;
    rmw_res_t          res_q, alu_res;
    logic [COST_W-1:0] cost_q, cost_nxt;

    rmw_alu u_alu (
        .req (req_q),
        .res (alu_res)
    );

    rmw_cost #(
        .COST_W       (COST_W),
        .CAS_REG_HIT  (CAS_REG_HIT),
        .CAS_REG_MISS (CAS_REG_MISS),
        .CAS_MEM_HIT  (CAS_MEM_HIT),
        .CAS_MEM_MISS (CAS_MEM_MISS),
        .XADD_REG     (XADD_REG),
        .XADD_MEM     (XADD_MEM)
    ) u_cost (
        .op     (req_q.op),
        .is_mem (req_q.is_mem),
        .hit    (alu_res.hit),
        .cost   (cost_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            res_q   <= '0;
            cost_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    req_q.op     <= rmw_op_e'(req_op);
                    req_q.wide   <= req_wide;
                    req_q.is_mem <= (req_modrm < REG_FORM_MIN);
                    req_q.acc    <= req_acc;
                    req_q.src    <= req_src;
                    req_q.dst    <= req_dst;
                    state_q      <= (req_modrm < REG_FORM_MIN) ? S_RD : S_CALC;
                end
                S_RD: if (mem_rd_ack) begin
                    req_q.dst <= mem_rd_data;
                    state_q   <= S_CALC;
                end
                S_CALC: begin
                    res_q   <= alu_res;
                    cost_q  <= cost_nxt;
                    state_q <= (req_q.is_mem && alu_res.dst_we) ? S_WR : S_FIN;
                end
                S_WR: if (mem_wr_ack) state_q <= S_FIN;
                S_FIN: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (state_q == S_IDLE);
        mem_rd_req  = (state_q == S_RD);
        mem_wr_req  = (state_q == S_WR);
        mem_wr_data = res_q.dst_val;
        mem_wide    = req_q.wide;
        mem_lock    = req_q.is_mem &&
                      (state_q == S_RD || state_q == S_CALC || state_q == S_WR);
        done        = (state_q == S_FIN);
        dst_wr_en   = done && res_q.dst_we && !req_q.is_mem;
        dst_wr_data = res_q.dst_val;
        acc_wr_en   = done && res_q.acc_we;
        acc_wr_data = res_q.reg_val;
        src_wr_en   = done && res_q.src_we;
        src_wr_data = res_q.reg_val;
        zf_wr_en    = done && res_q.zf_we;
        zf_value    = res_q.zf;
        cost        = done ? cost_q : '0;
    end
endmodule

// File: rtl/rmw_xchg_chk.sv
module rmw_xchg_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic mem_rd_req,
    input logic mem_rd_ack,
    input logic mem_wr_req,
    input logic mem_wr_ack,
    input logic mem_lock,
    input logic dst_wr_en,
    input logic acc_wr_en,
    input logic src_wr_en,
    input logic zf_wr_en,
    input logic zf_value,
    input logic done
);
    assert_lock_rd_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> mem_lock);
    assert_lock_wr_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req |-> mem_lock);
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_ack) |=> mem_rd_req);
    assert_wr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_wr_ack) |=> mem_wr_req);
    assert_single_access_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd_req, mem_wr_req}));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_strobe_in_done_R7: assert property (@(posedge clk) disable iff (rst)
        (dst_wr_en || acc_wr_en || src_wr_en || zf_wr_en) |-> done);
    assert_match_no_acc_R2: assert property (@(posedge clk) disable iff (rst)
        (zf_wr_en && zf_value) |-> !acc_wr_en);
    assert_miss_no_dst_R3: assert property (@(posedge clk) disable iff (rst)
        acc_wr_en |-> (!dst_wr_en && !mem_wr_req));
    assert_idle_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_lock && !done));
endmodule

bind rmw_xchg_unit rmw_xchg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .mem_rd_req (mem_rd_req),
    .mem_rd_ack (mem_rd_ack),
    .mem_wr_req (mem_wr_req),
    .mem_wr_ack (mem_wr_ack),
    .mem_lock   (mem_lock),
    .dst_wr_en  (dst_wr_en),
    .acc_wr_en  (acc_wr_en),
    .src_wr_en  (src_wr_en),
    .zf_wr_en   (zf_wr_en),
    .zf_value   (zf_value),
    .done       (done)
);

// File: tb/test_rmw_xchg_unit.sv
`timescale 1ns/1ps
module test_rmw_xchg_unit;
    localparam int CW = 6;
    localparam int C_RH = 21, C_RM = 22, C_MH = 23, C_MM = 24, C_XR = 25, C_XM = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_op = 1'b0, req_wide = 1'b0;
    logic [7:0]  req_modrm = '0;
    logic [15:0] req_acc = '0, req_src = '0, req_dst = '0;
    logic mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic req_ready, mem_rd_req, mem_wr_req, mem_wide, mem_lock;
    logic [15:0] mem_wr_data, dst_wr_data, acc_wr_data, src_wr_data;
    logic dst_wr_en, acc_wr_en, src_wr_en, zf_wr_en, zf_value, done;
    logic [CW-1:0] cost;

    int checks = 0, errors = 0;

    // results gathered by run_op
    logic        o_dst_en, o_acc_en, o_src_en, o_zf_en, o_zf, o_done, o_lock_bad, o_pulse_bad;
    logic [15:0] o_dst, o_acc, o_src, o_wr_data;
    logic [CW-1:0] o_cost;
    int          n_rd, n_wr;

    always #2.5 clk = ~clk;

    rmw_xchg_unit #(
        .COST_W(CW), .CAS_REG_HIT(C_RH), .CAS_REG_MISS(C_RM),
        .CAS_MEM_HIT(C_MH), .CAS_MEM_MISS(C_MM), .XADD_REG(C_XR), .XADD_MEM(C_XM)
    ) i_rmw_xchg_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_wide(req_wide), .req_modrm(req_modrm),
        .req_acc(req_acc), .req_src(req_src), .req_dst(req_dst),
        .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack), .mem_wr_data(mem_wr_data),
        .mem_wide(mem_wide), .mem_lock(mem_lock),
        .dst_wr_en(dst_wr_en), .dst_wr_data(dst_wr_data),
        .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
        .src_wr_en(src_wr_en), .src_wr_data(src_wr_data),
        .zf_wr_en(zf_wr_en), .zf_value(zf_value), .done(done), .cost(cost)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Drive one request and act as memory; capture everything seen up to done.
    task automatic run_op(input logic op, input logic wide, input logic [7:0] modrm,
                          input logic [15:0] acc, input logic [15:0] src,
                          input logic [15:0] dst, input logic [15:0] memv, input int lat);
        int waited = 0;
        o_dst_en = 0; o_acc_en = 0; o_src_en = 0; o_zf_en = 0; o_zf = 0; o_done = 0;
        o_lock_bad = 0; o_pulse_bad = 0; o_dst = '0; o_acc = '0; o_src = '0;
        o_wr_data = '0; o_cost = '0; n_rd = 0; n_wr = 0;
        @(negedge clk);
        req_valid = 1; req_op = op; req_wide = wide; req_modrm = modrm;
        req_acc = acc; req_src = src; req_dst = dst;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 60; i++) begin
            mem_rd_ack = 0; mem_wr_ack = 0;
            if ((mem_rd_req || mem_wr_req) && !mem_lock) o_lock_bad = 1;
            if (mem_rd_req) begin
                if (waited >= lat) begin
                    mem_rd_ack = 1; mem_rd_data = memv; n_rd++;
                end else waited++;
            end
            if (mem_wr_req) begin
                mem_wr_ack = 1; o_wr_data = mem_wr_data; n_wr++;
                if (mem_wide !== wide) o_lock_bad = 1;
            end
            if (done) begin
                o_done = 1;
                o_dst_en = dst_wr_en; o_dst = dst_wr_data;
                o_acc_en = acc_wr_en; o_acc = acc_wr_data;
                o_src_en = src_wr_en; o_src = src_wr_data;
                o_zf_en = zf_wr_en; o_zf = zf_value; o_cost = cost;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        if (done || mem_lock || cost != 0) o_pulse_bad = 1;
    endtask

    task automatic t_reset();
        check(req_ready === 1'b1, "R9 reset ready", req_ready, 1);
        check({done, mem_lock, mem_rd_req, mem_wr_req} === 4'b0, "R9 reset outputs",
              {done, mem_lock, mem_rd_req, mem_wr_req}, 0);
        check({dst_wr_en, acc_wr_en, src_wr_en, zf_wr_en} === 4'b0, "R9 reset strobes",
              {dst_wr_en, acc_wr_en, src_wr_en, zf_wr_en}, 0);
        check(cost === '0, "R8 reset cost", cost, 0);
    endtask

    task automatic t_cas_reg_hit();
        run_op(1'b0, 1'b1, 8'hC3, 16'h1234, 16'hBEEF, 16'h1234, 16'h0, 0);
        check(o_done, "R7 cas reg hit done", o_done, 1);
        check(n_rd == 0 && n_wr == 0, "R1 reg form no memory", n_rd + n_wr, 0);
        check(o_dst_en && o_dst == 16'hBEEF, "R2 cas reg hit dst", o_dst, 16'hBEEF);
        check(o_zf_en && o_zf, "R2 cas reg hit zf", o_zf, 1);
        check(!o_acc_en, "R2 cas reg hit acc untouched", o_acc_en, 0);
        check(o_cost == CW'(C_RH), "R8 cas reg hit cost", o_cost, C_RH);
        check(!o_pulse_bad, "R7 done single pulse", o_pulse_bad, 0);
    endtask

    task automatic t_cas_reg_miss();
        run_op(1'b0, 1'b1, 8'hFF, 16'h1111, 16'h5555, 16'h2222, 16'h0, 0);
        check(o_acc_en && o_acc == 16'h2222, "R3 cas reg miss acc", o_acc, 16'h2222);
        check(!o_dst_en, "R3 cas reg miss dst untouched", o_dst_en, 0);
        check(o_zf_en && !o_zf, "R3 cas reg miss zf", o_zf, 0);
        check(o_cost == CW'(C_RM), "R8 cas reg miss cost", o_cost, C_RM);
    endtask

    task automatic t_cas_mem_hit();
        run_op(1'b0, 1'b1, 8'h06, 16'hA5A5, 16'h0F0F, 16'h0, 16'hA5A5, 3);
        check(n_rd == 1 && n_wr == 1, "R6 cas mem hit one read one write", {n_rd[15:0], n_wr[15:0]}, 32'h00010001);
        check(o_wr_data == 16'h0F0F, "R2 cas mem hit write data", o_wr_data, 16'h0F0F);
        check(!o_dst_en && o_zf_en && o_zf, "R2 cas mem hit zf, no reg dst", {o_dst_en, o_zf}, 1);
        check(!o_lock_bad, "R6 lock during access", o_lock_bad, 0);
        check(o_cost == CW'(C_MH), "R8 cas mem hit cost", o_cost, C_MH);
    endtask

    task automatic t_cas_mem_miss();
        run_op(1'b0, 1'b1, 8'h45, 16'h0001, 16'h7777, 16'h0, 16'h8001, 0);
        check(n_rd == 1 && n_wr == 0, "R3 cas mem miss no write", n_wr, 0);
        check(o_acc_en && o_acc == 16'h8001, "R3 cas mem miss acc", o_acc, 16'h8001);
        check(o_zf_en && !o_zf, "R3 cas mem miss zf", o_zf, 0);
        check(o_cost == CW'(C_MM), "R8 cas mem miss cost", o_cost, C_MM);
        check(!o_pulse_bad, "R6 lock released after miss", o_pulse_bad, 0);
    endtask

    task automatic t_xadd_reg16();
        run_op(1'b1, 1'b1, 8'hD1, 16'h0, 16'h0020, 16'hFFF0, 16'h0, 0);
        check(o_dst_en && o_dst == 16'h0010, "R4 xadd reg wrap sum", o_dst, 16'h0010);
        check(o_src_en && o_src == 16'hFFF0, "R4 xadd reg old dst to src", o_src, 16'hFFF0);
        check(!o_zf_en && !o_acc_en, "R4 xadd no zf/acc update", {o_zf_en, o_acc_en}, 0);
        check(o_cost == CW'(C_XR), "R8 xadd reg cost", o_cost, C_XR);
    endtask

    task automatic t_xadd_mem8();
        run_op(1'b1, 1'b0, 8'hBF, 16'h0, 16'h3325, 16'h0, 16'h77F0, 2);
        check(n_rd == 1 && n_wr == 1, "R1 0xBF is memory form", n_rd + n_wr, 2);
        check(o_wr_data == 16'h0015, "R5 xadd mem8 sum masked", o_wr_data, 16'h0015);
        check(o_src_en && o_src == 16'h00F0, "R5 xadd mem8 old dst low byte", o_src, 16'h00F0);
        check(o_cost == CW'(C_XM), "R8 xadd mem cost", o_cost, C_XM);
        check(!o_lock_bad, "R6 lock and width on write", o_lock_bad, 0);
    endtask

    task automatic t_cas8_upper_ignored();
        run_op(1'b0, 1'b0, 8'hC0, 16'hAB12, 16'h99EE, 16'hCD12, 16'h0, 0);
        check(n_rd == 0, "R1 0xC0 is register form", n_rd, 0);
        check(o_dst_en && o_dst == 16'h00EE && o_zf, "R5 cas8 low-byte match", o_dst, 16'h00EE);
    endtask

    task automatic t_xadd_reg8();
        run_op(1'b1, 1'b0, 8'hC7, 16'h0, 16'h1201, 16'h34FF, 16'h0, 0);
        check(o_dst == 16'h0000 && o_dst_en, "R5 xadd8 wrap at 0xFF", o_dst, 0);
        check(o_src == 16'h00FF && o_src_en, "R5 xadd8 old dst", o_src, 16'h00FF);
        check(req_ready, "R9 ready after operation", req_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired, no completion");
        summary_and_end();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_cas_reg_hit();
        t_cas_reg_miss();
        t_cas_mem_hit();
        t_cas_mem_miss();
        t_xadd_reg16();
        t_xadd_mem8();
        t_cas8_upper_ignored();
        t_xadd_reg8();
        summary_and_end();
    end
endmodule